// File: doc/BRIEF.md
# Host Command Sequencer for a Learning Datapath

This block sits between a host-side word stream and a training datapath. After reset it waits for a configuration word. It then takes command words from the host and, for each one, loads training samples, hands control to the datapath, returns register values or moves finished results back toward the host.

Three FIFOs keep the traffic classes apart:

- **Data FIFO:** 1024 entries of 32 bits. It carries training samples to the datapath.
- **Result FIFO:** it collects what the datapath produces.
- **Output FIFO:** it feeds every word the host reads back.

Before a training run starts, the sequencer raises a DMA request. It holds that request until the host acknowledges it. It then issues a single-cycle start pulse and waits for the datapath's completion flag. Misuse never corrupts a FIFO: a write into a full FIFO or a read from an empty one is refused and recorded in a sticky status register. An unknown opcode is also refused and recorded there.

Top module: `host_cmd_sequencer`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to its idle state. It empties all three FIFOs and clears every status bit. While idle, `host_ready` and `dma_req` are low.
- R2: In the idle state, a cycle with `cfg_valid` high stores `host_data` as the configuration word and moves to command wait. A `host_valid` word in the idle state is ignored.
- R3: Opcode 0x1 loads data. The opcode is held in `host_data[31:28]` of the command word. This command accepts `host_data[10:0]` further words into the data FIFO and then returns to command wait; a count of zero stays in command wait. The data FIFO is 1024 x 32 and presents its oldest word on `dp_rdata` while `dp_avail` is high.
- R4: Opcode 0x2 starts training. `dma_req` rises and stays high, and nothing advances, until a cycle with `dma_ack` high. In the next cycle `dp_start` is high for exactly one cycle. The sequencer then waits for `dp_done` before taking another command.
- R5: Opcode 0x3 reads a register. It pushes the register selected by `host_data[1:0]` into the output FIFO:
  - 0: status.
  - 1: data FIFO fill count.
  - 2: result FIFO fill count.
  - 3: configuration word.
- R6: Opcode 0x4 drains results. It moves one result FIFO word into the output FIFO on each clock in which the output FIFO has room. It returns to command wait when the result FIFO is empty.
- R7: Any other opcode changes no FIFO or state. It sets status bit 5.
- R8: A refused access sets a sticky status bit that only reset clears.
  - Refused pushes into a full FIFO: bit 0 for the data FIFO, bit 2 for the result FIFO (`dp_res_valid`), bit 3 for the output FIFO (a register read).
  - Refused pops from an empty FIFO: bit 1 for the data FIFO (`dp_rd`), bit 4 for the output FIFO (`out_rd`).
- R9: `host_ready` is high in command wait, and during a data load while the data FIFO is not full. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration step strobe (idle state only) |
| host_valid | input | 1 | Host word strobe (command or load data) |
| host_data | input | 32 | Host word |
| host_ready | output | 1 | Sequencer can take a host word |
| dma_req | output | 1 | Bulk transfer request, held until acknowledged |
| dma_ack | input | 1 | Host acknowledge of `dma_req` |
| dp_start | output | 1 | One-cycle start pulse to the datapath |
| dp_done | input | 1 | Datapath completion flag |
| dp_rd | input | 1 | Datapath pops the data FIFO |
| dp_rdata | output | 32 | Oldest data FIFO word |
| dp_avail | output | 1 | Data FIFO not empty |
| dp_res_valid | input | 1 | Datapath pushes a result word |
| dp_res_data | input | 32 | Result word |
| out_rd | input | 1 | Host pops the output FIFO |
| out_data | output | 32 | Oldest output FIFO word |
| out_valid | output | 1 | Output FIFO not empty |

## Verification
On every cycle, the assertions check the handshake around training:

- The DMA request holds until it is acknowledged.
- The start pulse lasts one cycle and only follows an acknowledge.
- The sequencer is never ready for host words while the request is pending.
- Status bits never clear.
- Neither FIFO fill count goes past its depth.

The order of the data reaching the datapath and of the results reaching the host, the refused accesses at exact FIFO limits, the decoding of every opcode and the register contents can only be shown by the bench's scenarios. There, a queue-based reference model is compared against the outputs on every clock.

// File: rtl/host_cmd_sequencer.sv
module hcs_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

module host_cmd_sequencer #(
  parameter int DW     = 32,
  parameter int DDEPTH = 1024,
  parameter int RDEPTH = 16,
  parameter int ODEPTH = 16,
  localparam int DCW = $clog2(DDEPTH + 1),
  localparam int RCW = $clog2(RDEPTH + 1),
  localparam int OCW = $clog2(ODEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_valid,
  input  logic          host_valid,
  input  logic [DW-1:0] host_data,
  output logic          host_ready,
  output logic          dma_req,
  input  logic          dma_ack,
  output logic          dp_start,
  input  logic          dp_done,
  input  logic          dp_rd,
  output logic [DW-1:0] dp_rdata,
  output logic          dp_avail,
  input  logic          dp_res_valid,
  input  logic [DW-1:0] dp_res_data,
  input  logic          out_rd,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_LOAD, S_DMA, S_WAIT, S_DRAIN} st_t;

  st_t             st;
  logic [10:0]     cnt;
  logic [DW-1:0]   cfg, r_rdata, reg_val;
  logic [5:0]      sts;
  logic            start_q;
  logic [DCW-1:0]  d_count;
  logic [RCW-1:0]  r_count;
  logic [OCW-1:0]  o_count;
  logic            d_full, d_empty, r_full, r_empty, o_full, o_empty;
  logic            d_wr, reg_rd, drain_mv, bad_op, o_wr;
  logic [3:0]      op;

  assign op       = host_data[DW-1 -: 4];
  assign d_wr     = (st == S_LOAD) && host_valid;
  assign reg_rd   = (st == S_CMD) && host_valid && (op == 4'h3);
  assign bad_op   = (st == S_CMD) && host_valid && !(op inside {4'h1, 4'h2, 4'h3, 4'h4});
  assign drain_mv = (st == S_DRAIN) && !r_empty && !o_full;
  assign o_wr     = reg_rd || drain_mv;

  always_comb
    case (host_data[1:0])
      2'd0:    reg_val = DW'(sts);
      2'd1:    reg_val = DW'(d_count);
      2'd2:    reg_val = DW'(r_count);
      default: reg_val = cfg;
    endcase

  hcs_fifo #(.W(DW), .DEPTH(DDEPTH)) u_data (
    .clk, .rst, .wr(d_wr), .wdata(host_data), .rd(dp_rd), .rdata(dp_rdata),
    .full(d_full), .empty(d_empty), .count(d_count));

  hcs_fifo #(.W(DW), .DEPTH(RDEPTH)) u_res (
    .clk, .rst, .wr(dp_res_valid), .wdata(dp_res_data), .rd(drain_mv), .rdata(r_rdata),
    .full(r_full), .empty(r_empty), .count(r_count));

  hcs_fifo #(.W(DW), .DEPTH(ODEPTH)) u_out (
    .clk, .rst, .wr(o_wr), .wdata(drain_mv ? r_rdata : reg_val), .rd(out_rd), .rdata(out_data),
    .full(o_full), .empty(o_empty), .count(o_count));

  assign dp_avail   = !d_empty;
  assign out_valid  = !o_empty;
  assign dma_req    = (st == S_DMA);
  assign dp_start   = start_q;
  assign host_ready = (st == S_CMD) || ((st == S_LOAD) && !d_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; cfg <= '0; sts <= '0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      sts <= sts | {bad_op, out_rd && o_empty, reg_rd && o_full,
                    dp_res_valid && r_full, dp_rd && d_empty, d_wr && d_full};
      case (st)
        S_IDLE: if (cfg_valid) begin cfg <= host_data; st <= S_CMD; end
        S_CMD: if (host_valid)
          case (op)
            4'h1: if (host_data[10:0] != '0) begin cnt <= host_data[10:0]; st <= S_LOAD; end
            4'h2: st <= S_DMA;
            4'h4: st <= S_DRAIN;
            default: ;
          endcase
        S_LOAD: if (host_valid && !d_full) begin
          cnt <= cnt - 1'b1;
          if (cnt == 11'd1) st <= S_CMD;
        end
        S_DMA:   if (dma_ack) begin start_q <= 1'b1; st <= S_WAIT; end
        S_WAIT:  if (dp_done) st <= S_CMD;
        S_DRAIN: if (r_empty) st <= S_CMD;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module hcs_checker #(
  parameter int DDEPTH = 1024,
  parameter int ODEPTH = 16,
  parameter int DCW = 11,
  parameter int OCW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           dma_req,
  input logic           dma_ack,
  input logic           dp_start,
  input logic           host_ready,
  input logic [5:0]     sts,
  input logic [DCW-1:0] d_count,
  input logic [OCW-1:0] o_count
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack |=> dma_req);
  a_r4_start_after_ack: assert property (@(posedge clk) disable iff (rst)
    dp_start |-> $past(dma_req && dma_ack));
  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    dp_start |=> !dp_start);
  a_r9_not_ready_in_dma: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !host_ready);
  a_r8_sticky_status: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((sts & $past(sts)) == $past(sts)));
  a_r3_data_bound: assert property (@(posedge clk) disable iff (rst)
    d_count <= DCW'(DDEPTH));
  a_r6_out_bound: assert property (@(posedge clk) disable iff (rst)
    o_count <= OCW'(ODEPTH));
endmodule

bind host_cmd_sequencer hcs_checker #(.DDEPTH(DDEPTH), .ODEPTH(ODEPTH), .DCW(DCW), .OCW(OCW)) u_chk (
  .clk(clk), .rst(rst), .dma_req(dma_req), .dma_ack(dma_ack), .dp_start(dp_start),
  .host_ready(host_ready), .sts(sts), .d_count(d_count), .o_count(o_count));

// File: tb/host_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module host_cmd_sequencer_tb_top;
  localparam int DD = 1024, RD = 16, OD = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_valid = 0, host_valid = 0, dma_ack = 0, dp_done = 0;
  logic dp_rd = 0, dp_res_valid = 0, out_rd = 0;
  logic [31:0] host_data = '0, dp_res_data = '0;
  logic host_ready, dma_req, dp_start, dp_avail, out_valid;
  logic [31:0] dp_rdata, out_data;

  host_cmd_sequencer dut_i (.*);

  int vecs = 0, fails = 0;
  int mst = 0, mcnt = 0;
  logic [31:0] mcfg = '0;
  logic [5:0]  msts = '0;
  bit mstart = 0;
  logic [31:0] dq[$], rq[$], oq[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int dl, rl, ol, nst, ncnt;
    bit nstart, push_d, push_o, move;
    logic [31:0] ncfg, oval;
    logic [5:0] ns;
    if (rst) begin
      mst = 0; mcnt = 0; mcfg = '0; msts = '0; mstart = 0;
      dq.delete(); rq.delete(); oq.delete();
      return;
    end
    dl = dq.size(); rl = rq.size(); ol = oq.size();
    nst = mst; ncnt = mcnt; ncfg = mcfg; ns = msts; nstart = 0;
    push_d = 0; push_o = 0; move = 0; oval = '0;
    case (mst)
      0: if (cfg_valid) begin ncfg = host_data; nst = 1; end
      1: if (host_valid) begin
        case (host_data[31:28])
          4'h1: if (host_data[10:0] != 0) begin ncnt = int'(host_data[10:0]); nst = 2; end
          4'h2: nst = 3;
          4'h3: begin
            push_o = 1;
            case (host_data[1:0])
              0: oval = 32'(msts);
              1: oval = 32'(dl);
              2: oval = 32'(rl);
              default: oval = mcfg;
            endcase
          end
          4'h4: nst = 5;
          default: ns[5] = 1;
        endcase
      end
      2: if (host_valid) begin
        if (dl < DD) begin push_d = 1; ncnt = mcnt - 1; if (mcnt == 1) nst = 1; end
        else ns[0] = 1;
      end
      3: if (dma_ack) begin nst = 4; nstart = 1; end
      4: if (dp_done) nst = 1;
      5: if (rl == 0) nst = 1; else if (ol < OD) move = 1;
      default: ;
    endcase
    if (push_o && ol >= OD) begin push_o = 0; ns[3] = 1; end
    if (move) begin oval = rq[0]; push_o = 1; void'(rq.pop_front()); end
    if (dp_rd) begin if (dl > 0) void'(dq.pop_front()); else ns[1] = 1; end
    if (out_rd) begin if (ol > 0) void'(oq.pop_front()); else ns[4] = 1; end
    if (dp_res_valid) begin if (rl < RD) rq.push_back(dp_res_data); else ns[2] = 1; end
    if (push_d) dq.push_back(host_data);
    if (push_o) oq.push_back(oval);
    mst = nst; mcnt = ncnt; mcfg = ncfg; msts = ns; mstart = nstart;
  endtask

  task automatic compare();
    chk(host_ready == ((mst == 1) || (mst == 2 && dq.size() < DD)), "R9 host_ready", 32'(host_ready), 32'((mst == 1) || (mst == 2 && dq.size() < DD)));
    chk(dma_req == (mst == 3), "R4 dma_req", 32'(dma_req), 32'(mst == 3));
    chk(dp_start == mstart, "R4 dp_start", 32'(dp_start), 32'(mstart));
    chk(out_valid == (oq.size() > 0), "R6 out_valid", 32'(out_valid), 32'(oq.size() > 0));
    if (oq.size() > 0) chk(out_data == oq[0], "R6 out_data", out_data, oq[0]);
    chk(dp_avail == (dq.size() > 0), "R3 dp_avail", 32'(dp_avail), 32'(dq.size() > 0));
    if (dq.size() > 0) chk(dp_rdata == dq[0], "R3 dp_rdata", dp_rdata, dq[0]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cfg_valid = 0; host_valid = 0; dma_ack = 0; dp_done = 0;
    dp_rd = 0; dp_res_valid = 0; out_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send(logic [31:0] w);
    host_valid = 1; host_data = w; step();
  endtask

  task automatic read_reg(logic [1:0] sel, logic [31:0] exp, string tag);
    send({4'h3, 26'd0, sel});
    chk(out_valid && out_data == exp, tag, out_data, exp);
    out_rd = 1; step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; idle(3);
    rst = 0; step();
    chk(!host_ready && !dma_req && !out_valid && !dp_avail, "R1 reset state",
        {host_ready, dma_req, out_valid, dp_avail}, 32'h0);

    send(32'h1000_0003);
    chk(!host_ready, "R2 host word ignored in idle", 32'(host_ready), 32'h0);
    cfg_valid = 1; host_data = 32'hCAFE_0001; step();
    chk(host_ready, "R2 command wait after config", 32'(host_ready), 32'h1);
    read_reg(2'd3, 32'hCAFE_0001, "R5 config register");

    send(32'h7000_0000);
    read_reg(2'd0, 32'h20, "R7 bad opcode status");

    send(32'h1000_0000);
    chk(host_ready, "R3 zero-length load stays in command", 32'(host_ready), 32'h1);
    send(32'h1000_0005);
    for (int i = 0; i < 5; i++) begin
      send(32'hA0 + 32'(i));
      idle(i % 2);
    end
    read_reg(2'd1, 32'd5, "R5 data count");
    for (int i = 0; i < 6; i++) begin dp_rd = 1; step(); end
    read_reg(2'd0, 32'h22, "R8 data underflow");

    send(32'h2000_0000);
    idle(3);
    chk(dma_req, "R4 request held", 32'(dma_req), 32'h1);
    dma_ack = 1; step();
    chk(dp_start, "R4 start after ack", 32'(dp_start), 32'h1);
    for (int i = 0; i < 3; i++) begin
      dp_res_valid = 1; dp_res_data = 32'h5000 + 32'(i); step();
    end
    send(32'h3000_0000);
    chk(!out_valid, "R4 commands ignored while waiting", 32'(out_valid), 32'h0);
    dp_done = 1; step();

    read_reg(2'd2, 32'd3, "R5 result count");
    send(32'h4000_0000);
    idle(5);
    chk(out_valid && out_data == 32'h5000, "R6 first drained result", out_data, 32'h5000);
    for (int i = 0; i < 4; i++) begin out_rd = 1; step(); end
    read_reg(2'd0, 32'h32, "R8 output underflow");

    for (int i = 0; i < 17; i++) send(32'h3000_0001);
    for (int i = 0; i < 16; i++) begin out_rd = 1; step(); end
    for (int i = 0; i < 17; i++) begin
      dp_res_valid = 1; dp_res_data = 32'h7700 + 32'(i); step();
    end
    send(32'h4000_0000);
    idle(20);
    for (int i = 0; i < 20; i++) begin out_rd = 1; step(); end

    send(32'h1000_0401);
    for (int i = 0; i < 1025; i++) send(32'h9000_0000 + 32'(i));
    chk(!host_ready, "R9 not ready when data full", 32'(host_ready), 32'h0);
    dp_rd = 1; step();
    send(32'h9000_0400);
    read_reg(2'd0, 32'h3F, "R8 all sticky bits");
    read_reg(2'd1, 32'd1024, "R3 data FIFO full count");

    rst = 1; step();
    rst = 0; step();
    chk(!dp_avail && !out_valid && !host_ready, "R1 reset mid-operation",
        {dp_avail, out_valid, host_ready}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule